// File: doc/BRIEF.md
# Freeze-and-Drain Packet Statistics Bank

This block keeps per-direction packet statistics for a network port and exposes them through a narrow, synchronous register read port. Two directions are tracked, transmit and receive. Each direction counts good packets in a wide wrapping counter and errored packets in a narrow saturating counter. Both counters advance on one-cycle event strobes.

Software drains a direction with three reads. The first read takes a snapshot of that direction, so the three words returned describe one instant. Reading the low word, then the high word, then the error word, with nothing in between, empties the direction. The snapshot is released by any other pattern of reads, and nothing is cleared.

Events keep being counted while a snapshot is held. The events that arrive between the snapshot and the drain become the new starting value, so a drain never loses a packet.

Top module: `stat_bank`

## Requirements
- R1: Offsets 1, 2 and 3 belong to the transmit direction and offsets 4, 5 and 6 to the receive direction. Within a direction, the first offset returns bits DATA_W-1:0 of the good-packet count. The second returns bits 2*DATA_W-1:DATA_W. The third returns the error count, zero-extended.
- R2: Read data appears on `rd_data_o` in the cycle after `rd_en_i` is sampled high, and it holds its value in every cycle with no read.
- R3: A read of offset 0, or of any offset above 6, returns zero.
- R4: A read of the first offset of a direction that is not in a sequence freezes that direction. The next reads of its second and third offsets return values as of the freeze, even if events arrive in between.
- R5: Reading the first, second and third offsets of a direction as three back-to-back reads (idle cycles allowed) clears it. Its new count equals the events seen after the freeze, including those in the cycle of the third read.
- R6: Any other read during a sequence breaks it and releases the snapshot without clearing. This includes a repeated read of the first offset. The order 1, 2, 1, 2, 3 therefore leaves the counts intact.
- R7: A read of the other direction's offsets breaks a sequence in progress. Draining one direction never changes the other.
- R8: Error counters are ERR_W bits wide and stop at all ones instead of wrapping.
- R9: Good-packet counters are 2*DATA_W bits wide and wrap to zero after all ones.
- R10: While `rst_n` is low, all counts, snapshots and sequence state are zero and `rd_data_o` is zero.
- R11: After a broken sequence, the next read of a first offset starts a fresh freeze. A complete in-order sequence from there clears the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_good_i | input | 1 | One transmit good-packet event per cycle high |
| tx_err_i | input | 1 | One transmit error-packet event per cycle high |
| rx_good_i | input | 1 | One receive good-packet event per cycle high |
| rx_err_i | input | 1 | One receive error-packet event per cycle high |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Register offset to read |
| rd_data_o | output | DATA_W | Read data, valid the cycle after the strobe |

## Verification
The bench builds the bank with DATA_W=4, ERR_W=3 and ADDR_W=4. With these values the 8-bit good-packet counter wraps after 256 events and the error counter saturates at 7, so both limits are reached within a few hundred cycles. Offsets 7 to 15 remain available as undefined addresses. The bench drives snapshot, drain, broken-order and cross-direction sequences, with events arriving during and on the cycle of the clearing read.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int REGS_PER_GRP = 3;
  localparam int NUM_GRP      = 2;

  // Sequence position of one direction
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_WANT_HI = 2'd1,
    SEQ_WANT_ER = 2'd2
  } seq_state_e;
endpackage

// File: rtl/stat_add.sv
// Increment-by-strobe adder, wrapping or saturating
module stat_add #(
  parameter int W        = 16,
  parameter bit SATURATE = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic         inc_i,
  output logic [W-1:0] y_o
);
  generate
    if (SATURATE) begin : g_sat
      assign y_o = (inc_i && !(&a_i)) ? a_i + W'(1) : a_i;
    end else begin : g_wrap
      assign y_o = a_i + W'(inc_i);
    end
  endgenerate
endmodule

// File: rtl/stat_seq.sv
// Tracks the in-order read sequence of one direction
module stat_seq
  import stat_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en_i,
  input  logic [2:0] hit_i,
  output logic       freeze_o,
  output logic       clear_o,
  output logic       snap_hi_o,
  output logic       snap_er_o
);
  seq_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    freeze_o = 1'b0;
    clear_o  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (hit_i[0]) begin
          state_d  = SEQ_WANT_HI;
          freeze_o = 1'b1;
        end
      end
      SEQ_WANT_HI: state_d = hit_i[1] ? SEQ_WANT_ER : SEQ_IDLE;
      SEQ_WANT_ER: begin
        state_d = SEQ_IDLE;
        clear_o = hit_i[2];
      end
      default: state_d = SEQ_IDLE;
    endcase
    if (!rd_en_i) begin
      state_d  = state_q;
      freeze_o = 1'b0;
      clear_o  = 1'b0;
    end
  end

  assign state_en  = rd_en_i;
  assign snap_hi_o = (state_q == SEQ_WANT_HI);
  assign snap_er_o = (state_q == SEQ_WANT_ER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= SEQ_IDLE;
    else if (state_en) state_q <= state_d;
  end
endmodule

// File: rtl/stat_group.sv
// One direction: live, snapshot and shadow counters plus read select
module stat_group #(
  parameter int DATA_W = 16,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              good_i,
  input  logic              err_i,
  input  logic              rd_en_i,
  input  logic [2:0]        hit_i,
  output logic [DATA_W-1:0] rd_val_o,
  output logic              freeze_o,
  output logic              clear_o
);
  localparam int PKT_W = 2 * DATA_W;

  logic [PKT_W-1:0] live_pkt_q, live_pkt_d, snap_pkt_q, sh_pkt_q, sh_pkt_d;
  logic [ERR_W-1:0] live_err_q, live_err_d, snap_err_q, sh_err_q, sh_err_d;
  logic [PKT_W-1:0] live_pkt_inc, sh_pkt_inc;
  logic [ERR_W-1:0] live_err_inc, sh_err_inc;
  logic             pkt_en, err_en, sh_en, snap_en;
  logic             snap_hi, snap_er;

  stat_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .hit_i     (hit_i),
    .freeze_o  (freeze_o),
    .clear_o   (clear_o),
    .snap_hi_o (snap_hi),
    .snap_er_o (snap_er)
  );

  stat_add #(.W(PKT_W), .SATURATE(1'b0)) live_pkt_add_i (.a_i(live_pkt_q), .inc_i(good_i), .y_o(live_pkt_inc));
  stat_add #(.W(PKT_W), .SATURATE(1'b0)) sh_pkt_add_i   (.a_i(sh_pkt_q),   .inc_i(good_i), .y_o(sh_pkt_inc));
  stat_add #(.W(ERR_W), .SATURATE(1'b1)) live_err_add_i (.a_i(live_err_q), .inc_i(err_i),  .y_o(live_err_inc));
  stat_add #(.W(ERR_W), .SATURATE(1'b1)) sh_err_add_i   (.a_i(sh_err_q),   .inc_i(err_i),  .y_o(sh_err_inc));

  always_comb begin
    live_pkt_d = clear_o ? sh_pkt_inc : live_pkt_inc;
    live_err_d = clear_o ? sh_err_inc : live_err_inc;
    sh_pkt_d   = freeze_o ? PKT_W'(good_i) : sh_pkt_inc;
    sh_err_d   = freeze_o ? ERR_W'(err_i)  : sh_err_inc;
    pkt_en     = good_i | clear_o;
    err_en     = err_i | clear_o;
    sh_en      = good_i | err_i | freeze_o;
    snap_en    = freeze_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_pkt_q <= '0;
      live_err_q <= '0;
      snap_pkt_q <= '0;
      snap_err_q <= '0;
      sh_pkt_q   <= '0;
      sh_err_q   <= '0;
    end else begin
      if (pkt_en)  live_pkt_q <= live_pkt_d;
      if (err_en)  live_err_q <= live_err_d;
      if (snap_en) snap_pkt_q <= live_pkt_q;
      if (snap_en) snap_err_q <= live_err_q;
      if (sh_en)   sh_pkt_q   <= sh_pkt_d;
      if (sh_en)   sh_err_q   <= sh_err_d;
    end
  end

  // Low word reads live: on a freeze the snapshot equals it
  always_comb begin
    rd_val_o = '0;
    if (hit_i[0])
      rd_val_o = live_pkt_q[DATA_W-1:0];
    else if (hit_i[1])
      rd_val_o = snap_hi ? snap_pkt_q[PKT_W-1:DATA_W] : live_pkt_q[PKT_W-1:DATA_W];
    else if (hit_i[2])
      rd_val_o = snap_er ? DATA_W'(snap_err_q) : DATA_W'(live_err_q);
  end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ERR_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_good_i,
  input  logic              tx_err_i,
  input  logic              rx_good_i,
  input  logic              rx_err_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_GRP-1:0] good_vec, err_vec;
  logic [NUM_GRP-1:0] grp_freeze, grp_clear;
  logic [DATA_W-1:0]  grp_val [NUM_GRP];
  logic [DATA_W-1:0]  rd_data_d, rd_data_q;
  logic               rd_data_en;

  assign good_vec = {rx_good_i, tx_good_i};
  assign err_vec  = {rx_err_i,  tx_err_i};

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [2:0] hit;
      for (genvar r = 0; r < REGS_PER_GRP; r++) begin : g_hit
        localparam int OFS = g * REGS_PER_GRP + 1 + r;
        assign hit[r] = (rd_addr_i == ADDR_W'(OFS));
      end
      stat_group #(.DATA_W(DATA_W), .ERR_W(ERR_W)) grp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .good_i   (good_vec[g]),
        .err_i    (err_vec[g]),
        .rd_en_i  (rd_en_i),
        .hit_i    (hit),
        .rd_val_o (grp_val[g]),
        .freeze_o (grp_freeze[g]),
        .clear_o  (grp_clear[g])
      );
    end
  endgenerate

  always_comb begin
    rd_data_d = '0;
    for (int g = 0; g < NUM_GRP; g++) rd_data_d = rd_data_d | grp_val[g];
    rd_data_en = rd_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data_q <= '0;
    else if (rd_data_en) rd_data_q <= rd_data_d;
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 4,
  parameter int NUM_GRP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NUM_GRP-1:0] grp_freeze,
  input logic [NUM_GRP-1:0] grp_clear
);
  localparam int LAST_OFS = NUM_GRP * 3;

  // R3
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (rd_addr_i == '0 || rd_addr_i > ADDR_W'(LAST_OFS))) |=> (rd_data_o == '0));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));

  // R10
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data_o == '0));

  // R7
  one_seq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grp_freeze, grp_clear}));

  // R5
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_clear) |-> rd_en_i);
endmodule

bind stat_bank stat_bank_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .NUM_GRP (2)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .grp_freeze (grp_freeze),
  .grp_clear  (grp_clear)
);

// File: tb/stat_bank_tb_top.sv
`timescale 1ns/1ps
module stat_bank_tb_top;
  localparam int DW = 4;
  localparam int EW = 3;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tx_good, tx_err, rx_good, rx_err, rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done  = 1'b0;

  always #2 clk = ~clk;

  stat_bank #(.DATA_W(DW), .ERR_W(EW), .ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_good_i (tx_good),
    .tx_err_i  (tx_err),
    .rx_good_i (rx_good),
    .rx_err_i  (rx_err),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // One cycle: drive at negedge, return read data at the next negedge
  task automatic step(input bit rd, input int addr, input bit tg, input bit te,
                      input bit rg, input bit re, output int data);
    rd_en = rd; rd_addr = AW'(addr);
    tx_good = tg; tx_err = te; rx_good = rg; rx_err = re;
    @(negedge clk);
    data = int'(rd_data);
    rd_en = 1'b0; tx_good = 1'b0; tx_err = 1'b0; rx_good = 1'b0; rx_err = 1'b0;
  endtask

  task automatic events(input bit tg, input bit te, input bit rg, input bit re, input int n);
    int d;
    for (int i = 0; i < n; i++) step(1'b0, 0, tg, te, rg, re, d);
  endtask

  task automatic rd_chk(input int addr, input int exp, input string req);
    int d;
    step(1'b1, addr, 1'b0, 1'b0, 1'b0, 1'b0, d);
    check(req, d, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd_en = 1'b0; rd_addr = '0;
    tx_good = 1'b0; tx_err = 1'b0; rx_good = 1'b0; rx_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 rd_data after reset", int'(rd_data), 0);
    for (int a = 1; a <= 6; a++) rd_chk(a, 0, "R10 count after reset");
  endtask

  task automatic t_basic();
    do_reset();
    events(1, 0, 0, 0, 5);
    events(0, 1, 0, 0, 2);
    rd_chk(1, 5, "R1 tx low word");
    rd_chk(2, 0, "R1 tx high word");
    rd_chk(3, 2, "R1 tx error word");
    rd_chk(1, 0, "R5 tx cleared");
  endtask

  task automatic t_freeze();
    int d;
    do_reset();
    events(0, 0, 1, 0, 30);
    rd_chk(4, 14, "R4 rx low word at freeze");
    events(0, 0, 1, 0, 3);
    events(0, 0, 0, 1, 2);
    rd_chk(5, 1, "R4 rx high word from snapshot");
    step(1'b1, 6, 1'b0, 1'b0, 1'b1, 1'b0, d);
    check("R4 rx error word from snapshot", d, 0);
    rd_chk(4, 4, "R5 events during freeze kept");
    rd_chk(5, 0, "R5 high word after drain");
    rd_chk(6, 2, "R5 errors during freeze kept");
  endtask

  task automatic t_broken();
    do_reset();
    events(1, 0, 0, 0, 7);
    events(0, 1, 0, 0, 1);
    rd_chk(1, 7, "R6 seq 1");
    rd_chk(2, 0, "R6 seq 2");
    rd_chk(1, 7, "R6 repeated first");
    rd_chk(2, 0, "R6 seq 2 again");
    rd_chk(3, 1, "R6 seq 3");
    rd_chk(1, 7, "R6 not cleared, R11 fresh freeze");
    rd_chk(2, 0, "R11 fresh seq 2");
    rd_chk(3, 1, "R11 fresh seq 3");
    rd_chk(1, 0, "R11 cleared after fresh sequence");
  endtask

  task automatic t_cross();
    do_reset();
    events(1, 0, 0, 0, 3);
    rd_chk(1, 3, "R7 tx first");
    rd_chk(4, 0, "R7 rx read mid tx sequence");
    rd_chk(2, 0, "R7 tx second");
    rd_chk(3, 0, "R7 tx third");
    rd_chk(1, 3, "R7 tx not cleared");
    rd_chk(0, 0, "R3 offset 0 reads zero");
    rd_chk(2, 0, "R3 tx second after undefined");
    rd_chk(3, 0, "R3 tx third after undefined");
    rd_chk(9, 0, "R3 offset 9 reads zero");
    rd_chk(15, 0, "R3 offset 15 reads zero");
    rd_chk(1, 3, "R6 tx still intact");
    events(0, 0, 1, 0, 2);
    rd_chk(2, 0, "R7 tx second");
    rd_chk(3, 0, "R7 tx third drains");
    rd_chk(4, 2, "R7 rx unaffected by tx drain");
    rd_chk(1, 0, "R7 tx drained");
  endtask

  task automatic t_sat();
    do_reset();
    events(0, 1, 0, 0, 10);
    rd_chk(3, 7, "R8 error count saturates");
    events(0, 1, 0, 0, 1);
    rd_chk(3, 7, "R8 error count stays saturated");
  endtask

  task automatic t_wrap();
    do_reset();
    events(1, 0, 0, 0, 255);
    rd_chk(1, 15, "R9 low word at 255");
    rd_chk(2, 15, "R9 high word at 255");
    events(1, 0, 0, 0, 5);
    rd_chk(1, 4, "R9 low word after wrap");
    rd_chk(2, 0, "R9 high word after wrap");
  endtask

  task automatic t_hold();
    do_reset();
    events(0, 0, 1, 0, 9);
    rd_chk(4, 9, "R2 read value");
    events(0, 0, 1, 1, 3);
    check("R2 data held without read", int'(rd_data), 9);
    @(negedge clk);
    check("R2 data still held", int'(rd_data), 9);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_freeze();
    t_broken();
    t_cross();
    t_sat();
    t_wrap();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule